// File: doc/BRIEF.md
# Host Ownership Lock and Boot-Gated Identity Registers

This block holds two kinds of register behind one small synchronous register bus. The first is a 16-bit host identifier field that works as an ownership token. It starts at the all-ones value, which means free. The first requester to write its own identifier claims the field. A write of any other value is then ignored. The owner gives the field back by writing its own identifier a second time. Any requester reads the field after its write to learn whether it now holds the lock.

The second kind is a pair of identity words: an assembly identifier and an assembly information word. Software may rewrite both until a boot-done input is seen high. From then on both stay frozen until reset. The block also drives the lock state, the current owner value and one-cycle pulses that mark each claim and each release, so nearby logic can follow ownership without polling.

Accesses are single cycles. A write takes effect at the clock edge where `bus_wr` is high. Read data depends combinationally on `bus_addr`. There is no handshake. The control and status pins are plain levels and pulses.

Top module: `hostid_lock_regs`

## Requirements
- R1: After reset, the host field reads 0xFFFF. `lock_held`, `claim_pulse` and `drop_pulse` are low. The assembly identifier reads 0x00001A2B and the assembly information word reads 0x00000003.
- R2: While the field is 0xFFFF, a write to address 0 of a value other than 0xFFFF stores `bus_wdata[15:0]`. `lock_held` is high from the next cycle, and `claim_pulse` is high for exactly that one cycle.
- R3: While the field is not 0xFFFF, a write to address 0 whose low 16 bits differ from the stored value leaves the field unchanged and raises no pulse.
- R4: While the field is not 0xFFFF, a write to address 0 whose low 16 bits equal the stored value sets the field back to 0xFFFF. `drop_pulse` is high for exactly the next cycle.
- R5: While the field is 0xFFFF, a write of 0xFFFF leaves the field free and raises no pulse.
- R6: Address 0 reads the field in bits 15:0 with zeros above. `owner_id` always equals the field. `lock_held` is high exactly when the field is not 0xFFFF.
- R7: While boot-done has never been high, writes to address 1 (assembly identifier) and address 2 (assembly information) store all 32 bits, and the stored values read back.
- R8: A write to address 1 or 2 in a cycle where `boot_done` is high is ignored, including the very first cycle it is high.
- R9: Once `boot_done` has been high at any clock edge, writes to addresses 1 and 2 stay ignored until reset, even after `boot_done` returns low.
- R10: Address 3 reads zero. A write to one address never changes the value held at another address. The host field keeps its lock behaviour after boot-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 2 | Register select: 0 host field, 1 assembly id, 2 assembly info, 3 spare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| boot_done | input | 1 | Boot-complete level, sampled at each write edge |
| lock_held | output | 1 | High while the host field is owned |
| owner_id | output | 16 | Current host field value |
| claim_pulse | output | 1 | One-cycle pulse after a successful claim |
| drop_pulse | output | 1 | One-cycle pulse after a release |

## Verification
The two functions that can meet in one cycle are a write to an identity word and the first rise of boot-done. The bench drives `boot_done` high in the same cycle as an assembly-word write, then reads the word back and expects the value from before that write. It then lowers `boot_done` again and writes once more, and expects the value still to be frozen. A second meeting in one cycle is a host-field write that lands just after a release. The bench expects a fresh claim there and checks that it raises `claim_pulse` and not `drop_pulse`.

// File: rtl/hostid_pkg.sv
package hostid_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_HOST  = 2'd0,
    SEL_ASMID = 2'd1,
    SEL_ASMIN = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  localparam int NUM_IDREG = 2;
endpackage

// File: rtl/hostid_own_field.sv
module hostid_own_field #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [ID_W-1:0] wr_val,
  output logic [ID_W-1:0] field,
  output logic            claim_pulse,
  output logic            drop_pulse
);
  localparam logic [ID_W-1:0] FREE_VAL = {ID_W{1'b1}};

  logic is_free;
  logic do_claim;
  logic do_drop;

  assign is_free  = (field == FREE_VAL);
  assign do_claim = wr_hit && is_free && (wr_val != FREE_VAL);
  assign do_drop  = wr_hit && !is_free && (wr_val == field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field       <= FREE_VAL;
      claim_pulse <= 1'b0;
      drop_pulse  <= 1'b0;
    end else begin
      claim_pulse <= do_claim;
      drop_pulse  <= do_drop;
      if (do_claim)     field <= wr_val;
      else if (do_drop) field <= FREE_VAL;
    end
  end

  // R2: a claim pulse follows a change from free to owned
  assert_claim_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    claim_pulse |-> (field != FREE_VAL) && ($past(field) == FREE_VAL));

  // R3: an owned field only moves on a matching write
  assert_owned_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((field != FREE_VAL) && !(wr_hit && (wr_val == field))) |=> $stable(field));

  // R4: a drop pulse follows a return to free
  assert_drop_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> (field == FREE_VAL) && ($past(field) != FREE_VAL));

  // R5: a free field stays free unless a non-free value is written
  assert_free_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((field == FREE_VAL) && !(wr_hit && (wr_val != FREE_VAL))) |=> (field == FREE_VAL));

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({claim_pulse, drop_pulse}) <= 1);
endmodule

// File: rtl/hostid_boot_gate.sv
module hostid_boot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_done,
  output logic wr_allow
);
  logic boot_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         boot_seen <= 1'b0;
    else if (boot_done) boot_seen <= 1'b1;
  end

  assign wr_allow = !boot_done && !boot_seen;

  // R9: once seen, the boot state never clears before reset
  assert_boot_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_seen |=> boot_seen);

  // R8: the level itself blocks writes in the cycle it is high
  assert_boot_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !wr_allow);
endmodule

// File: rtl/hostid_id_word.sv
module hostid_id_word #(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              wr_allow,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= RST_VAL[DATA_W-1:0];
    else if (wr_hit && wr_allow) q <= wr_val;
  end

  // R9: a frozen word never changes
  assert_frozen_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(q));

  // R10: a write to another address leaves this word alone
  assert_no_stray_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));
endmodule

// File: rtl/hostid_lock_regs.sv
module hostid_lock_regs #(
  parameter int          DATA_W       = 32,
  parameter int          ID_W         = 16,
  parameter logic [31:0] ASM_ID_RST   = 32'h0000_1A2B,
  parameter logic [31:0] ASM_INFO_RST = 32'h0000_0003
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [hostid_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         boot_done,
  output logic                         lock_held,
  output logic [ID_W-1:0]              owner_id,
  output logic                         claim_pulse,
  output logic                         drop_pulse
);
  import hostid_pkg::*;

  localparam logic [ID_W-1:0] FREE_VAL = {ID_W{1'b1}};

  logic [ID_W-1:0]   host_field;
  logic              wr_allow;
  logic              host_hit;
  logic [DATA_W-1:0] id_q [NUM_IDREG];

  assign host_hit = bus_wr && (bus_addr == SEL_HOST);

  hostid_own_field #(.ID_W(ID_W)) u_own (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (host_hit),
    .wr_val      (bus_wdata[ID_W-1:0]),
    .field       (host_field),
    .claim_pulse (claim_pulse),
    .drop_pulse  (drop_pulse)
  );

  hostid_boot_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_done (boot_done),
    .wr_allow  (wr_allow)
  );

  for (genvar g = 0; g < NUM_IDREG; g++) begin : g_idw
    localparam logic [31:0] RV = (g == 0) ? ASM_ID_RST : ASM_INFO_RST;
    logic hit;
    assign hit = bus_wr && (bus_addr == ADDR_W'(g + 1));
    hostid_id_word #(.DATA_W(DATA_W), .RST_VAL(RV)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit),
      .wr_allow (wr_allow),
      .wr_val   (bus_wdata),
      .q        (id_q[g])
    );
  end

  assign owner_id  = host_field;
  assign lock_held = (host_field != FREE_VAL);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      SEL_HOST:  bus_rdata[ID_W-1:0] = host_field;
      SEL_ASMID: bus_rdata = id_q[0];
      SEL_ASMIN: bus_rdata = id_q[1];
      default:   bus_rdata = '0;
    endcase
  end

  // R6: lock level follows the owner value
  assert_lock_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_held == (owner_id != FREE_VAL));
endmodule

// File: tb/hostid_lock_regs_bench.sv
module hostid_lock_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        boot_done = 1'b0;
  logic        lock_held;
  logic [15:0] owner_id;
  logic        claim_pulse;
  logic        drop_pulse;

  int checks = 0;
  int errors = 0;
  logic        rd_vld = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  hostid_lock_regs u_hostid_lock_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boot_done(boot_done),
    .lock_held(lock_held), .owner_id(owner_id),
    .claim_pulse(claim_pulse), .drop_pulse(drop_pulse)
  );

  // scoreboard monitor: compares read data against queued expectations
  always @(negedge clk) begin
    if (rd_vld && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    bus_addr = a; rd_vld = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_vld = 1'b0;
  endtask

  task automatic flags(input string t, input logic l, input logic c, input logic d);
    chk({t, " lock"}, {31'd0, lock_held}, {31'd0, l});
    chk({t, " claim"}, {31'd0, claim_pulse}, {31'd0, c});
    chk({t, " drop"}, {31'd0, drop_pulse}, {31'd0, d});
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    flags("R1", 1'b0, 1'b0, 1'b0);
    rd(2'd0, 32'h0000_FFFF, "R1 host");
    rd(2'd1, 32'h0000_1A2B, "R1 asmid");
    rd(2'd2, 32'h0000_0003, "R1 asminfo");
    // R5 writing the free value
    wr(2'd0, 32'h0000_FFFF);
    flags("R5", 1'b0, 1'b0, 1'b0);
    // R2 claim
    wr(2'd0, 32'hDEAD_0012);
    flags("R2 claim", 1'b1, 1'b1, 1'b0);
    chk("R6 owner", {16'd0, owner_id}, 32'h0000_0012);
    @(posedge clk); #1;
    flags("R2 one cycle", 1'b1, 1'b0, 1'b0);
    // R3 differing write ignored
    wr(2'd0, 32'h0000_0034);
    flags("R3", 1'b1, 1'b0, 1'b0);
    rd(2'd0, 32'h0000_0012, "R3 host");
    // R4 matching write releases (upper bits ignored)
    wr(2'd0, 32'h5555_0012);
    flags("R4 release", 1'b0, 1'b0, 1'b1);
    chk("R6 owner free", {16'd0, owner_id}, 32'h0000_FFFF);
    // re-claim right after release
    wr(2'd0, 32'h0000_0034);
    flags("R2 reclaim", 1'b1, 1'b1, 1'b0);
    rd(2'd0, 32'h0000_0034, "R6 host read");
    // R7 identity writes before boot
    wr(2'd1, 32'hCAFE_0001);
    wr(2'd2, 32'h1234_5678);
    rd(2'd1, 32'hCAFE_0001, "R7 asmid");
    rd(2'd2, 32'h1234_5678, "R7 asminfo");
    // R10 spare and isolation
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R10 spare");
    rd(2'd0, 32'h0000_0034, "R10 host untouched");
    rd(2'd1, 32'hCAFE_0001, "R10 asmid untouched");
    // R8 write in the cycle boot_done rises
    boot_done = 1'b1;
    wr(2'd1, 32'h0BAD_0BAD);
    rd(2'd1, 32'hCAFE_0001, "R8 asmid");
    // R9 sticky after boot_done falls
    boot_done = 1'b0;
    wr(2'd2, 32'h0BAD_0BAD);
    wr(2'd1, 32'h0BAD_0BAD);
    rd(2'd2, 32'h1234_5678, "R9 asminfo");
    rd(2'd1, 32'hCAFE_0001, "R9 asmid");
    // R10 host lock still works after boot
    wr(2'd0, 32'h0000_0034);
    flags("R10 release after boot", 1'b0, 1'b0, 1'b1);
    rd(2'd0, 32'h0000_FFFF, "R10 host free");
    @(posedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule